// File: doc/BRIEF.md
# Dual-line level interrupt controller

The block gathers a vector of level-sensitive interrupt sources and drives two request lines toward a processor: a normal request line and a fast request line. Both lines look at the same raw source vector. Each line has its own enable mask, and the line is high whenever any source that is asserted is also enabled for that line. Software changes a mask through a pair of addresses. One address sets the bits written as ones and the other clears them, so no read-modify-write sequence is needed.

Source 0 can also be raised by software through a set/clear latch. It is the OR of the hardware input and that latch. Software reads the raw vector and the masked vector for each line through a word-addressed register bus. The bus is plain control access: strobes, no handshake, one access per cycle. Read data comes back in the cycle after the read strobe, and the bus never stalls. Controllers can be cascaded: the request line of a secondary controller is wired to source 26 of a primary, and the secondary's fast line is left open.

Top module: `dual_line_intc`

## Requirements
- R1: After reset both enable masks are zero and the source-0 latch is clear, so both request lines are low whatever the sources do.
- R2: Reading word 1 or word 9 returns the raw vector: the source inputs ORed with the source-0 latch in bit 0.
- R3: A write to word 2 (normal line) or word 10 (fast line) ORs the write data into that line's mask. A read of the same word returns the mask.
- R4: A write to word 3 (normal line) or word 11 (fast line) clears the mask bits that are one in the write data and leaves the others alone.
- R5: Reading word 0 returns raw AND normal mask. Reading word 8 returns raw AND fast mask.
- R6: irq_o is high exactly when raw AND normal mask is nonzero, and fiq_o likewise for the fast mask. The two lines are independent. A mask write shows on the lines in the cycle after the write, and a source change shows in the same cycle.
- R7: A write to word 4 with data bit 0 set asserts the source-0 latch. With bit 0 clear the write has no effect. A read of word 4 returns raw bit 0 in bit 0 and zeros above it.
- R8: A write to word 5 with data bit 0 set clears the latch. An asserted hardware source 0 stays visible in raw bit 0.
- R9: Reads of the write-only words 3, 5 and 11 return zero and raise bus_bad.
- R10: Writes to the status words 0, 1, 8 and 9 change no state and raise bus_bad.
- R11: Words 6, 7 and 12 to 15 read as zero, ignore writes, and raise bus_bad on either access.
- R12: bus_rdata carries the read value in the cycle after bus_rd and is zero in any cycle that does not follow a read. bus_bad is a one-cycle pulse in the cycle after the offending access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level-sensitive source inputs |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| bus_bad | output | 1 | Bad-access pulse, the cycle after the access |
| irq_o | output | 1 | Normal request line |
| fiq_o | output | 1 | Fast request line |

## Verification
A mask bit that is wrong internally shows up at the ports in one of two ways. The first is a read of word 2 or 10, one cycle after the read. The second is a request line that does or does not fire for a source that is present, one cycle after the write that should have set the bit. A stuck or lost source-0 latch is exposed by reading word 4 or word 1, and by a request line that stays up after the clear. The bench brings each such state out through reads right after the stimulus, so a divergence is visible within two cycles of its cause.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int unsigned NLINE    = 2;
  localparam int unsigned LINE_IRQ = 0;
  localparam int unsigned LINE_FIQ = 1;
  localparam int unsigned ADDR_W   = 4;

  typedef enum logic [ADDR_W-1:0] {
    W_IRQ_MSK = 4'd0,
    W_IRQ_RAW = 4'd1,
    W_IRQ_ENS = 4'd2,
    W_IRQ_ENC = 4'd3,
    W_SW_SET  = 4'd4,
    W_SW_CLR  = 4'd5,
    W_FIQ_MSK = 4'd8,
    W_FIQ_RAW = 4'd9,
    W_FIQ_ENS = 4'd10,
    W_FIQ_ENC = 4'd11
  } word_e;

  typedef struct packed {
    logic [NLINE-1:0] en_set;
    logic [NLINE-1:0] en_clr;
    logic             sw_set;
    logic             sw_clr;
  } wr_dec_t;

endpackage

// File: rtl/intc_decode.sv
module intc_decode
  import intc_pkg::*;
(
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  output wr_dec_t           dec,
  output logic              bad
);

  logic readable;
  logic writable;

  always_comb begin
    readable = 1'b0;
    writable = 1'b0;
    case (addr)
      W_IRQ_MSK, W_IRQ_RAW, W_FIQ_MSK, W_FIQ_RAW: readable = 1'b1;
      W_IRQ_ENS, W_FIQ_ENS, W_SW_SET: begin
        readable = 1'b1;
        writable = 1'b1;
      end
      W_IRQ_ENC, W_FIQ_ENC, W_SW_CLR: writable = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    dec                   = '0;
    dec.en_set[LINE_IRQ]  = wr && (addr == W_IRQ_ENS);
    dec.en_clr[LINE_IRQ]  = wr && (addr == W_IRQ_ENC);
    dec.en_set[LINE_FIQ]  = wr && (addr == W_FIQ_ENS);
    dec.en_clr[LINE_FIQ]  = wr && (addr == W_FIQ_ENC);
    dec.sw_set            = wr && (addr == W_SW_SET);
    dec.sw_clr            = wr && (addr == W_SW_CLR);
  end

  assign bad = (rd && !readable) || (wr && !writable);

endmodule

// File: rtl/intc_mask_reg.sv
module intc_mask_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
    end else if (set_stb) begin
      mask <= mask | wdata;
    end else if (clr_stb) begin
      mask <= mask & ~wdata;
    end
  end

endmodule

// File: rtl/intc_swsrc.sv
module intc_swsrc (
  input  logic clk,
  input  logic rst_n,
  input  logic set_stb,
  input  logic clr_stb,
  input  logic bit0,
  output logic latch_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
    end else if (set_stb && bit0) begin
      latch_q <= 1'b1;
    end else if (clr_stb && bit0) begin
      latch_q <= 1'b0;
    end
  end

endmodule

// File: rtl/intc_readback.sv
module intc_readback
  import intc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      raw,
  input  logic [W-1:0]      irq_en,
  input  logic [W-1:0]      fiq_en,
  input  logic              bad_in,
  output logic [W-1:0]      rdata,
  output logic              bad_q
);

  logic [W-1:0] sel;

  always_comb begin
    case (addr)
      W_IRQ_MSK: sel = raw & irq_en;
      W_IRQ_RAW: sel = raw;
      W_IRQ_ENS: sel = irq_en;
      W_SW_SET:  sel = {{(W-1){1'b0}}, raw[0]};
      W_FIQ_MSK: sel = raw & fiq_en;
      W_FIQ_RAW: sel = raw;
      W_FIQ_ENS: sel = fiq_en;
      default:   sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      bad_q <= 1'b0;
    end else begin
      rdata <= rd ? sel : '0;
      bad_q <= bad_in;
    end
  end

endmodule

// File: rtl/dual_line_intc.sv
module dual_line_intc
  import intc_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NSRC-1:0]   bus_wdata,
  output logic [NSRC-1:0]   bus_rdata,
  output logic              bus_bad,
  output logic              irq_o,
  output logic              fiq_o
);

  wr_dec_t          dec;
  logic             bad_now;
  logic             sw_q;
  logic [NSRC-1:0]  raw;
  logic [NSRC-1:0]  mask_q [NLINE];
  logic [NLINE-1:0] line;
  logic [NSRC-1:0]  irq_en;
  logic [NSRC-1:0]  fiq_en;

  intc_decode u_dec (
    .wr   (bus_wr),
    .rd   (bus_rd),
    .addr (bus_addr),
    .dec  (dec),
    .bad  (bad_now)
  );

  intc_swsrc u_sw (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_stb (dec.sw_set),
    .clr_stb (dec.sw_clr),
    .bit0    (bus_wdata[0]),
    .latch_q (sw_q)
  );

  assign raw = src_i | {{(NSRC-1){1'b0}}, sw_q};

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    intc_mask_reg #(.W(NSRC)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_stb (dec.en_set[g]),
      .clr_stb (dec.en_clr[g]),
      .wdata   (bus_wdata),
      .mask    (mask_q[g])
    );
    assign line[g] = |(raw & mask_q[g]);
  end

  assign irq_en = mask_q[LINE_IRQ];
  assign fiq_en = mask_q[LINE_FIQ];
  assign irq_o  = line[LINE_IRQ];
  assign fiq_o  = line[LINE_FIQ];

  intc_readback #(.W(NSRC)) u_rb (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd     (bus_rd),
    .addr   (bus_addr),
    .raw    (raw),
    .irq_en (irq_en),
    .fiq_en (fiq_en),
    .bad_in (bad_now),
    .rdata  (bus_rdata),
    .bad_q  (bus_bad)
  );

endmodule

// File: rtl/intc_chk.sv
module intc_chk
  import intc_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   src_i,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NSRC-1:0]   bus_wdata,
  input logic [NSRC-1:0]   bus_rdata,
  input logic              bus_bad,
  input logic              irq_o,
  input logic              fiq_o,
  input logic [NSRC-1:0]   irq_en,
  input logic [NSRC-1:0]   fiq_en,
  input logic              sw_q
);

  // R3
  irq_en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == W_IRQ_ENS) |=> ((irq_en & $past(bus_wdata)) == $past(bus_wdata)));

  // R4
  fiq_en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == W_FIQ_ENC) |=> ((fiq_en & $past(bus_wdata)) == '0));

  // R5
  irq_mask_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == W_IRQ_MSK) |=>
      (bus_rdata == ($past(src_i | {{(NSRC-1){1'b0}}, sw_q}) & $past(irq_en))));

  // R6
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_en != '0));

  // R6
  fiq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> (fiq_en != '0));

  // R9
  wo_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && (bus_addr == W_IRQ_ENC || bus_addr == W_SW_CLR || bus_addr == W_FIQ_ENC))
      |=> (bus_rdata == '0 && bus_bad));

  // R10
  stat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == W_IRQ_MSK || bus_addr == W_IRQ_RAW || bus_addr == W_FIQ_MSK || bus_addr == W_FIQ_RAW))
      |=> ($stable(irq_en) && $stable(fiq_en) && $stable(sw_q)));

  // R12
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd && !bus_wr) |=> (bus_rdata == '0 && !bus_bad));

endmodule

bind dual_line_intc intc_chk #(.NSRC(NSRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_i     (src_i),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_bad   (bus_bad),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o),
  .irq_en    (irq_en),
  .fiq_en    (fiq_en),
  .sw_q      (sw_q)
);

// File: tb/dual_line_intc_tb.sv
module dual_line_intc_tb;

  typedef struct packed {
    logic [31:0] src;
    logic        wr;
    logic        rd;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [31:0] exp_rd;
    logic        exp_bad;
    logic        exp_irq;
    logic        exp_fiq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_0010, 1'b0, 1'b1, 4'd1,  32'h0,          32'h0000_0010, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
    '{32'h0000_0010, 1'b1, 1'b0, 4'd2,  32'h0000_0030,  32'h0,         1'b0, 1'b1, 1'b0, 4'd6},  // R3 R6
    '{32'h0000_0010, 1'b1, 1'b0, 4'd2,  32'h0000_0100,  32'h0,         1'b0, 1'b1, 1'b0, 4'd3},  // R3
    '{32'h0000_0010, 1'b0, 1'b1, 4'd2,  32'h0,          32'h0000_0130, 1'b0, 1'b1, 1'b0, 4'd3},  // R3
    '{32'h0000_0010, 1'b0, 1'b1, 4'd0,  32'h0,          32'h0000_0010, 1'b0, 1'b1, 1'b0, 4'd5},  // R5
    '{32'h0000_0010, 1'b1, 1'b0, 4'd3,  32'h0000_0010,  32'h0,         1'b0, 1'b0, 1'b0, 4'd4},  // R4
    '{32'h0000_0100, 1'b0, 1'b1, 4'd0,  32'h0,          32'h0000_0100, 1'b0, 1'b1, 1'b0, 4'd5},  // R5
    '{32'h0000_0100, 1'b1, 1'b0, 4'd10, 32'h8000_0100,  32'h0,         1'b0, 1'b1, 1'b1, 4'd6},  // R6
    '{32'h0000_0100, 1'b0, 1'b1, 4'd8,  32'h0,          32'h0000_0100, 1'b0, 1'b1, 1'b1, 4'd5},  // R5
    '{32'h0000_0100, 1'b0, 1'b1, 4'd10, 32'h0,          32'h8000_0100, 1'b0, 1'b1, 1'b1, 4'd3},  // R3
    '{32'h0000_0000, 1'b1, 1'b0, 4'd11, 32'h0000_0100,  32'h0,         1'b0, 1'b0, 1'b0, 4'd4},  // R4
    '{32'h0000_0000, 1'b1, 1'b0, 4'd4,  32'h0000_0001,  32'h0,         1'b0, 1'b0, 1'b0, 4'd7},  // R7
    '{32'h0000_0000, 1'b0, 1'b1, 4'd4,  32'h0,          32'h0000_0001, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
    '{32'h0000_0000, 1'b0, 1'b1, 4'd1,  32'h0,          32'h0000_0001, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
    '{32'h0000_0000, 1'b0, 1'b1, 4'd9,  32'h0,          32'h0000_0001, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
    '{32'h0000_0000, 1'b1, 1'b0, 4'd2,  32'h0000_0001,  32'h0,         1'b0, 1'b1, 1'b0, 4'd6},  // R6
    '{32'h0000_0001, 1'b1, 1'b0, 4'd5,  32'h0000_0001,  32'h0,         1'b0, 1'b1, 1'b0, 4'd8},  // R8
    '{32'h0000_0001, 1'b0, 1'b1, 4'd4,  32'h0,          32'h0000_0001, 1'b0, 1'b1, 1'b0, 4'd8},  // R8
    '{32'h0000_0000, 1'b0, 1'b1, 4'd4,  32'h0,          32'h0000_0000, 1'b0, 1'b0, 1'b0, 4'd8},  // R8
    '{32'h0000_0000, 1'b1, 1'b0, 4'd4,  32'h0000_0002,  32'h0,         1'b0, 1'b0, 1'b0, 4'd7},  // R7
    '{32'h0000_0000, 1'b0, 1'b1, 4'd4,  32'h0,          32'h0000_0000, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
    '{32'h0000_0000, 1'b0, 1'b1, 4'd3,  32'h0,          32'h0,         1'b1, 1'b0, 1'b0, 4'd9},  // R9
    '{32'h0000_0000, 1'b0, 1'b1, 4'd5,  32'h0,          32'h0,         1'b1, 1'b0, 1'b0, 4'd9},  // R9
    '{32'h0000_0000, 1'b0, 1'b1, 4'd11, 32'h0,          32'h0,         1'b1, 1'b0, 1'b0, 4'd9},  // R9
    '{32'h0000_0000, 1'b1, 1'b0, 4'd0,  32'hFFFF_FFFF,  32'h0,         1'b1, 1'b0, 1'b0, 4'd10}, // R10
    '{32'h0000_0000, 1'b0, 1'b1, 4'd2,  32'h0,          32'h0000_0121, 1'b0, 1'b0, 1'b0, 4'd10}, // R10
    '{32'h0000_0000, 1'b1, 1'b0, 4'd9,  32'hFFFF_FFFF,  32'h0,         1'b1, 1'b0, 1'b0, 4'd10}, // R10
    '{32'h0000_0000, 1'b0, 1'b1, 4'd10, 32'h0,          32'h8000_0000, 1'b0, 1'b0, 1'b0, 4'd10}, // R10
    '{32'h0000_0000, 1'b0, 1'b1, 4'd6,  32'h0,          32'h0,         1'b1, 1'b0, 1'b0, 4'd11}, // R11
    '{32'h0000_0000, 1'b1, 1'b0, 4'd13, 32'hFFFF_FFFF,  32'h0,         1'b1, 1'b0, 1'b0, 4'd11}, // R11
    '{32'h0000_0000, 1'b0, 1'b1, 4'd2,  32'h0,          32'h0000_0121, 1'b0, 1'b0, 1'b0, 4'd11}, // R11
    '{32'h0000_0000, 1'b0, 1'b1, 4'd10, 32'h0,          32'h8000_0000, 1'b0, 1'b0, 1'b0, 4'd11}, // R11
    '{32'h8000_0000, 1'b0, 1'b1, 4'd8,  32'h0,          32'h8000_0000, 1'b0, 1'b0, 1'b1, 4'd6},  // R6
    '{32'h8000_0001, 1'b0, 1'b1, 4'd0,  32'h0,          32'h0000_0001, 1'b0, 1'b1, 1'b1, 4'd5}   // R5
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_bad;
  logic        irq_o;
  logic        fiq_o;

  int applied = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  dual_line_intc u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_bad   (bus_bad),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o)
  );

  task automatic check(input string tag, input logic [31:0] rd_e, input logic bad_e,
                       input logic irq_e, input logic fiq_e);
    applied++;
    if (bus_rdata !== rd_e || bus_bad !== bad_e || irq_o !== irq_e || fiq_o !== fiq_e) begin
      miscompares++;
      $display("FAIL %s: rdata=%h bad=%b irq=%b fiq=%b expected rdata=%h bad=%b irq=%b fiq=%b",
               tag, bus_rdata, bus_bad, irq_o, fiq_o, rd_e, bad_e, irq_e, fiq_e);
    end
  endtask

  task automatic access(input logic [31:0] s, input logic w, input logic r,
                        input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    src_i = s; bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    #1;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    // R1: lines stay low in reset with all sources high
    src_i = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check("R1 in reset", 32'h0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    access(32'hFFFF_FFFF, 1'b0, 1'b1, 4'd2, 32'h0);
    check("R1 irq mask after reset", 32'h0, 1'b0, 1'b0, 1'b0);
    access(32'hFFFF_FFFF, 1'b0, 1'b1, 4'd10, 32'h0);
    check("R1 fiq mask after reset", 32'h0, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].src, VEC[i].wr, VEC[i].rd, VEC[i].addr, VEC[i].data);
      check($sformatf("R%0d vector %0d", VEC[i].req, i),
            VEC[i].exp_rd, VEC[i].exp_bad, VEC[i].exp_irq, VEC[i].exp_fiq);
    end

    // R12: read data lasts one cycle, then returns to zero
    access(32'h0000_0005, 1'b0, 1'b1, 4'd1, 32'h0);
    check("R12 read data", 32'h0000_0005, 1'b0, 1'b1, 1'b0);
    @(negedge clk); #1;
    check("R12 idle after read", 32'h0, 1'b0, 1'b1, 1'b0);

    // R12: bad pulse lasts one cycle
    access(32'h0, 1'b1, 1'b0, 4'd7, 32'h1);
    check("R12 bad pulse", 32'h0, 1'b1, 1'b0, 1'b0);
    @(negedge clk); #1;
    check("R12 bad pulse ends", 32'h0, 1'b0, 1'b0, 1'b0);

    // R6: mask write reaches the line in the cycle after the write
    access(32'h0000_0040, 1'b1, 1'b0, 4'd10, 32'h0000_0040);
    check("R6 fiq up after mask write", 32'h0, 1'b0, 1'b0, 1'b1);

    // R1: reset in mid-run clears masks and latch
    access(32'h0, 1'b1, 1'b0, 4'd4, 32'h1);
    @(negedge clk);
    rst_n = 1'b0;
    src_i = 32'hFFFF_FFFF;
    #1;
    check("R1 mid-run reset lines", 32'h0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    access(32'h0, 1'b0, 1'b1, 4'd4, 32'h0);
    check("R1 latch cleared by reset", 32'h0, 1'b0, 1'b0, 1'b0);
    access(32'h0, 1'b0, 1'b1, 4'd2, 32'h0);
    check("R1 irq mask cleared by reset", 32'h0, 1'b0, 1'b0, 1'b0);

    finish_run();
  end

endmodule